// File: doc/BRIEF.md
# Handshaked Byte Output Port

This block is a CPU-side parallel port that runs in byte-output mode. It sits on a bus whose control lines are all active low: a chip select, an I/O request, a read strobe and a machine-cycle marker. The block has no write line. It treats any selected I/O access with read inactive as a write. A write to the data address puts the bus byte on the port pins and signals the peripheral with a ready flag. The peripheral takes the byte and answers with a rising edge on its strobe line. That edge drops ready and can raise an interrupt request.

The interrupt request is gated by an enable bit in a control register. It is also gated by a priority-in line that comes from a daisy chain. While a request is pending, priority-out is held low so that devices further down the chain are blocked. An interrupt-acknowledge cycle clears the pending request when this block has priority. A machine-cycle pulse with neither read nor I/O request active acts as a soft reset. Accesses never need wait states. Reads of the data address return the output register on a separately enabled data output.

Top module: `hs_out_port`

## Requirements
- R1: A write is recognised on a rising clock edge where cs_n=0, iorq_n=0, rd_n=1 and m1_n=1. With sel_ctl=0 it loads d_in into pout at that edge. pout changes on no other event except rst_n.
- R2: d_oe is 1, and d_out equals pout, exactly while cs_n=0, iorq_n=0, rd_n=0, m1_n=1 and sel_ctl=0. d_oe is 0 otherwise, including reads with sel_ctl=1.
- R3: rdy rises on the falling clock edge that follows the rising edge that captured a data write.
- R4: rdy stays high until the peripheral strobe rises. stb passes through two flip-flops first. rdy clears on the falling edge after the second rising edge that sees stb high.
- R5: A strobe rise while rdy is low is ignored: rdy stays low and no interrupt request is made.
- R6: A write with sel_ctl=1 sets the interrupt enable to d_in bit 7. The other bits have no effect.
- R7: A strobe rise that clears rdy drives int_n low at the same falling edge, if the interrupt enable is 1 and iei is 1. Otherwise int_n stays high.
- R8: ieo equals iei while no request is pending, and is 0 while int_n is low.
- R9: An acknowledge cycle (m1_n=0, iorq_n=0) with iei=1 releases int_n to 1 on the next falling edge. It does not reset the block.
- R10: m1_n=0 with rd_n=1 and iorq_n=1 clears rdy, the pending request and the interrupt enable, and keeps pout. m1_n=0 with rd_n=0 (opcode fetch) changes nothing.
- R11: rst_n=0 asynchronously clears pout, rdy, the interrupt enable and the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Chip select, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Machine-cycle marker, active low |
| sel_ctl | input | 1 | Address select: 0 data register, 1 control register |
| d_in | input | 8 | Bus data toward the block |
| d_out | output | 8 | Bus data from the block during a data read |
| d_oe | output | 1 | Drive enable for d_out |
| pout | output | 8 | Port pins carrying the output register |
| rdy | output | 1 | Data-available flag to the peripheral |
| stb | input | 1 | Peripheral strobe, asynchronous, acted on at its rising edge |
| iei | input | 1 | Daisy-chain priority in, active high |
| ieo | output | 1 | Daisy-chain priority out, active high |
| int_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that bus control inputs change only between clock edges. They also assume that iei keeps the same value from a rising edge through the following falling edge, so that the pending request and the checked value see the same priority level. The bench drives every input one time unit after a rising edge. It holds each bus access for exactly one rising edge. It leaves the strobe high or low for three cycles at a time, so that the synchroniser sees every edge.

// File: rtl/hsop_pkg.sv
package hsop_pkg;

  localparam int DATA_W   = 8;
  localparam int SYNC_LEN = 2;

  // selected I/O access with read inactive and no machine cycle
  function automatic logic f_is_write(input logic cs_n, input logic iorq_n,
                                      input logic rd_n, input logic m1_n);
    return ~cs_n & ~iorq_n & rd_n & m1_n;
  endfunction

  function automatic logic f_is_read(input logic cs_n, input logic iorq_n,
                                     input logic rd_n, input logic m1_n);
    return ~cs_n & ~iorq_n & ~rd_n & m1_n;
  endfunction

  // machine cycle alone is the soft reset
  function automatic logic f_is_m1_reset(input logic m1_n, input logic rd_n,
                                         input logic iorq_n);
    return ~m1_n & rd_n & iorq_n;
  endfunction

  function automatic logic f_is_ack(input logic m1_n, input logic iorq_n);
    return ~m1_n & ~iorq_n;
  endfunction

endpackage

// File: rtl/hsop_bus_dec.sv
module hsop_bus_dec
  import hsop_pkg::*;
(
  input  logic cs_n,
  input  logic iorq_n,
  input  logic rd_n,
  input  logic m1_n,
  input  logic sel_ctl,
  output logic wr_data,
  output logic wr_ctl,
  output logic rd_data,
  output logic m1_rst,
  output logic int_ack
);

  logic wr_any;

  always_comb begin
    wr_any  = f_is_write(cs_n, iorq_n, rd_n, m1_n);
    wr_data = wr_any & ~sel_ctl;
    wr_ctl  = wr_any & sel_ctl;
    rd_data = f_is_read(cs_n, iorq_n, rd_n, m1_n) & ~sel_ctl;
    m1_rst  = f_is_m1_reset(m1_n, rd_n, iorq_n);
    int_ack = f_is_ack(m1_n, iorq_n);
  end

endmodule

// File: rtl/hsop_stb_sync.sv
module hsop_stb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic stb_rise
);

  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], stb};
  end

  // last synchronised stage high, extra history stage still low
  assign stb_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/hsop_hs_core.sv
module hsop_hs_core #(
  parameter int DW     = 8,
  parameter int IE_BIT = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_ctl,
  input  logic          m1_rst,
  input  logic          int_ack,
  input  logic [DW-1:0] d_in,
  input  logic          stb_rise,
  input  logic          iei,
  output logic [DW-1:0] pout_q,
  output logic          wr_q,
  output logic          ie_q,
  output logic          rdy_q,
  output logic          pend_q
);

  logic stb_hit;

  assign stb_hit = stb_rise & rdy_q;

  // rising-edge side: bus capture and control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pout_q <= '0;
      wr_q   <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      wr_q <= wr_data;
      if (wr_data) pout_q <= d_in;
      if (m1_rst)      ie_q <= 1'b0;
      else if (wr_ctl) ie_q <= d_in[IE_BIT];
    end
  end

  // falling-edge side: handshake flag and interrupt request
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (m1_rst) begin
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_q)         rdy_q <= 1'b1;
      else if (stb_hit) rdy_q <= 1'b0;
      if (stb_hit && ie_q && iei) pend_q <= 1'b1;
      else if (int_ack && iei)    pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/hs_out_port.sv
module hs_out_port
  import hsop_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int SYNC_N = SYNC_LEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          m1_n,
  input  logic          sel_ctl,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  output logic [DW-1:0] pout,
  output logic          rdy,
  input  logic          stb,
  input  logic          iei,
  output logic          ieo,
  output logic          int_n
);

  localparam int IE_BIT = DW - 1;

  logic wr_data, wr_ctl, rd_data, m1_rst, int_ack;
  logic stb_rise, wr_q, ie_q, rdy_q, pend_q;
  logic [DW-1:0] pout_q;

  hsop_bus_dec u_dec (
    .cs_n    (cs_n),
    .iorq_n  (iorq_n),
    .rd_n    (rd_n),
    .m1_n    (m1_n),
    .sel_ctl (sel_ctl),
    .wr_data (wr_data),
    .wr_ctl  (wr_ctl),
    .rd_data (rd_data),
    .m1_rst  (m1_rst),
    .int_ack (int_ack)
  );

  hsop_stb_sync #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .stb_rise (stb_rise)
  );

  hsop_hs_core #(.DW(DW), .IE_BIT(IE_BIT)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_data  (wr_data),
    .wr_ctl   (wr_ctl),
    .m1_rst   (m1_rst),
    .int_ack  (int_ack),
    .d_in     (d_in),
    .stb_rise (stb_rise),
    .iei      (iei),
    .pout_q   (pout_q),
    .wr_q     (wr_q),
    .ie_q     (ie_q),
    .rdy_q    (rdy_q),
    .pend_q   (pend_q)
  );

  assign pout  = pout_q;
  assign rdy   = rdy_q;
  assign int_n = ~pend_q;
  assign ieo   = iei & ~pend_q;
  assign d_oe  = rd_data;
  assign d_out = rd_data ? pout_q : '0;

endmodule

// File: rtl/hsop_chk.sv
module hsop_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          iorq_n,
  input logic          rd_n,
  input logic          m1_n,
  input logic          iei,
  input logic          ieo,
  input logic          int_n,
  input logic          rdy,
  input logic          d_oe,
  input logic [DW-1:0] pout,
  input logic          wr_q,
  input logic          stb_rise,
  input logic          ie_q
);

  p_rdy_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> wr_q);

  p_irq_from_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> (stb_rise && ie_q && iei));

  p_chain_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> !ieo);

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n && rd_n && iorq_n) |=> (!rdy && int_n && !ie_q));

  p_pout_only_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pout) |-> wr_q);

  p_drive_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (!rd_n && !cs_n && !iorq_n && m1_n));

endmodule

bind hs_out_port hsop_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .iorq_n   (iorq_n),
  .rd_n     (rd_n),
  .m1_n     (m1_n),
  .iei      (iei),
  .ieo      (ieo),
  .int_n    (int_n),
  .rdy      (rdy),
  .d_oe     (d_oe),
  .pout     (pout),
  .wr_q     (wr_q),
  .stb_rise (stb_rise),
  .ie_q     (ie_q)
);

// File: tb/test_hs_out_port.sv
module test_hs_out_port;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
  logic       sel_ctl = 1'b0;
  logic [7:0] d_in = 8'h00;
  logic [7:0] d_out, pout;
  logic       d_oe, rdy, ieo, int_n;
  logic       stb = 1'b0;
  logic       iei = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_out_port i_hs_out_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .m1_n(m1_n), .sel_ctl(sel_ctl), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .pout(pout), .rdy(rdy), .stb(stb), .iei(iei), .ieo(ieo), .int_n(int_n)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit         m_rdy, m_pend, m_ie, m_wrote;
  logic [7:0] m_pout;
  bit         stb_seen[$];

  function automatic bit bus_io();
    return (cs_n == 1'b0) && (iorq_n == 1'b0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pout = 8'h00; m_ie = 0; m_wrote = 0;
      stb_seen.delete();
      repeat (3) stb_seen.push_back(1'b0);
    end else begin
      stb_seen.push_back(stb);
      if (stb_seen.size() > 6) void'(stb_seen.pop_front());
      m_wrote = 0;
      if (m1_n == 1'b0 && rd_n == 1'b1 && iorq_n == 1'b1) m_ie = 0;
      else if (bus_io() && rd_n && m1_n) begin
        if (sel_ctl) m_ie = d_in[7];
        else begin m_pout = d_in; m_wrote = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      m_rdy = 0; m_pend = 0;
    end else if (m1_n == 1'b0 && rd_n == 1'b1 && iorq_n == 1'b1) begin
      m_rdy = 0; m_pend = 0;
    end else begin
      automatic int n = stb_seen.size();
      automatic bit edge_seen = stb_seen[n-2] && !stb_seen[n-3];
      automatic bit taken = edge_seen && m_rdy;
      if (m_wrote)    m_rdy = 1;
      else if (taken) m_rdy = 0;
      if (taken && m_ie && iei)                 m_pend = 1;
      else if (!m1_n && !iorq_n && iei)         m_pend = 0;
    end
  end

  // compare every cycle, late in the cycle
  always @(posedge clk) begin
    #8;
    if (rst_n && !done) begin
      automatic bit exp_oe = bus_io() && !rd_n && m1_n && !sel_ctl;
      check("R3", "rdy", {7'b0, rdy}, {7'b0, m_rdy});
      check("R7", "int_n", {7'b0, int_n}, {7'b0, !m_pend});
      check("R8", "ieo", {7'b0, ieo}, {7'b0, iei && !m_pend});
      check("R1", "pout", pout, m_pout);
      check("R2", "d_oe", {7'b0, d_oe}, {7'b0, exp_oe});
      if (exp_oe) check("R2", "d_out", d_out, m_pout);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_idle();
    cs_n = 1; iorq_n = 1; rd_n = 1; m1_n = 1; sel_ctl = 0;
  endtask

  task automatic bus_cyc(input logic c, input logic io, input logic r,
                         input logic m, input logic s, input logic [7:0] d);
    @(posedge clk); #1;
    cs_n = c; iorq_n = io; rd_n = r; m1_n = m; sel_ctl = s; d_in = d;
    @(posedge clk); #1;
    bus_idle();
  endtask

  task automatic wr_data_t(input logic [7:0] d); bus_cyc(0, 0, 1, 1, 0, d); endtask
  task automatic wr_ctl_t(input logic [7:0] d);  bus_cyc(0, 0, 1, 1, 1, d); endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #8;
  endtask

  task automatic rd_probe(input logic s, input logic exp_oe, input logic [7:0] exp_d);
    @(posedge clk); #1;
    cs_n = 0; iorq_n = 0; rd_n = 0; m1_n = 1; sel_ctl = s;
    #6;
    check("R2", "read d_oe", {7'b0, d_oe}, {7'b0, exp_oe});
    if (exp_oe) check("R2", "read d_out", d_out, exp_d);
    @(posedge clk); #1;
    bus_idle();
  endtask

  task automatic strobe_pulse();
    @(posedge clk); #1; stb = 1;
    repeat (3) @(posedge clk);
    #1; stb = 0;
    repeat (3) @(posedge clk);
  endtask

  // ---------------- scenario ----------------
  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    settle(1);
    check("R11", "reset rdy", {7'b0, rdy}, 8'h00);
    check("R11", "reset int_n", {7'b0, int_n}, 8'h01);
    check("R11", "reset pout", pout, 8'h00);
    check("R11", "reset d_oe", {7'b0, d_oe}, 8'h00);

    wr_ctl_t(8'h80);
    wr_data_t(8'hA5);
    settle(0);
    check("R1", "pout after write", pout, 8'hA5);
    check("R3", "rdy after write", {7'b0, rdy}, 8'h01);
    settle(5);
    check("R4", "rdy held without strobe", {7'b0, rdy}, 8'h01);
    rd_probe(0, 1, 8'hA5);
    rd_probe(1, 0, 8'h00);

    strobe_pulse(); settle(1);
    check("R4", "rdy cleared by strobe", {7'b0, rdy}, 8'h00);
    check("R7", "request raised", {7'b0, int_n}, 8'h00);
    check("R8", "chain blocked", {7'b0, ieo}, 8'h00);

    bus_cyc(1, 0, 1, 0, 0, 8'h00); settle(1);
    check("R9", "ack releases request", {7'b0, int_n}, 8'h01);
    check("R8", "chain passes", {7'b0, ieo}, 8'h01);
    check("R9", "ack keeps pout", pout, 8'hA5);

    strobe_pulse(); settle(1);
    check("R5", "edge with rdy low no request", {7'b0, int_n}, 8'h01);
    check("R5", "edge with rdy low rdy", {7'b0, rdy}, 8'h00);

    wr_ctl_t(8'h7F); wr_data_t(8'h3C);
    strobe_pulse(); settle(1);
    check("R6", "bit7 clear disables request", {7'b0, int_n}, 8'h01);
    check("R4", "rdy cleared", {7'b0, rdy}, 8'h00);

    wr_ctl_t(8'h80);
    @(posedge clk); #1 iei = 0;
    wr_data_t(8'h11);
    strobe_pulse(); settle(1);
    check("R7", "no request without priority", {7'b0, int_n}, 8'h01);
    check("R8", "ieo follows low iei", {7'b0, ieo}, 8'h00);
    @(posedge clk); #1 iei = 1;

    wr_data_t(8'h22);
    bus_cyc(1, 1, 0, 0, 0, 8'h00); settle(1);
    check("R10", "fetch keeps rdy", {7'b0, rdy}, 8'h01);
    bus_cyc(1, 1, 1, 0, 0, 8'h00); settle(1);
    check("R10", "soft reset clears rdy", {7'b0, rdy}, 8'h00);
    check("R10", "soft reset keeps pout", pout, 8'h22);

    wr_data_t(8'h33);
    strobe_pulse(); settle(1);
    check("R10", "enable cleared by soft reset", {7'b0, int_n}, 8'h01);

    wr_ctl_t(8'h80); wr_data_t(8'h44);
    strobe_pulse(); settle(1);
    check("R7", "request raised again", {7'b0, int_n}, 8'h00);
    bus_cyc(1, 1, 1, 0, 0, 8'h00); settle(1);
    check("R10", "soft reset drops request", {7'b0, int_n}, 8'h01);

    settle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule